// File: doc/BRIEF.md
# Bidirectional Port Controller with Peripheral Pin Takeover

This block runs an 8-bit general-purpose I/O port from a small register bus. Software sets a direction latch and an output latch and reads back two views of the pins. The first is a data view that depends on direction. The second is a raw pad view that shows the real pin level whether or not the pin is driving. Each pin can be claimed by a pulse-width channel. While a channel is enabled it forces its pin to drive and supplies the pin level, and the stored direction bit is left alone.

One pin, the most significant by default, also has a shutdown control. While shutdown is asserted, that pin stops driving. This wins over both the direction latch and the pulse-width takeover.

Pad inputs reach the registers through a synchronizer of two flip-flops on the bus clock. A change on a pad therefore shows up in a read only after a fixed delay. Read data comes back one cycle after the request.

Top module: `gpio_ovr_port`

## Requirements
- R1: After reset the direction latch and the output latch are 0, every `pad_oe` bit is 0, and `bus_rdata` is 0.
- R2: Address 2 holds the direction latch, and it can be written and read back at any time. Where no override applies, a direction bit of 1 drives `pad_oe` high for that pin from the cycle after the write, and a bit of 0 drives it low.
- R3: While `pwm_en[i]` is 1 (and shutdown does not apply to pin i), `pad_oe[i]` is 1 and `pad_out[i]` equals `pwm_val[i]`. The direction latch keeps its written value.
- R4: While `shdn_en` is 1, `pad_oe[7]` is 0 whatever `pwm_en[7]` or direction bit 7 hold. The other pins are not affected, and the direction latch is not changed.
- R5: A read of address 1 (pad view) returns the synchronized pad level of every pin in either direction, so a driven pin whose pad disagrees with the output latch reads the pad level.
- R6: A pad change applied just before clock edge E is returned by a pad-view read sampled at edge E+2 or later. Reads sampled at E or E+1 return the earlier level.
- R7: A read of address 0 (data view) returns, per bit, the output latch where the pin is effectively driving (direction, pulse-width takeover and shutdown all taken into account) and the synchronized pad level where it is not.
- R8: Address 0 writes the output latch, and `pad_out[i]` equals latch bit i whenever `pwm_en[i]` is 0.
- R9: Writes to address 1 and address 3 change no state, and address 3 reads as 0.
- R10: `bus_rdata` carries the addressed value in the cycle after a read is sampled, and it is 0 in the cycle after any edge without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 2 | Register select: 0 data, 1 pad view, 2 direction, 3 reserved |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pwm_en | input | 8 | Per-pin pulse-width takeover enable |
| pwm_val | input | 8 | Per-pin pulse-width output level |
| shdn_en | input | 1 | Shutdown for the top pin, forces it to input |
| pad_oe | output | 8 | Pad output enable per pin |
| pad_out | output | 8 | Pad drive level per pin |
| pad_in | input | 8 | Raw pad level per pin |

## Verification
The bench steps a pad change through the synchronizer with three reads in a row. A design with one stage too few would return the new level a cycle early, and one with an extra stage would return it a cycle late. It enables takeover and shutdown together on the top pin, which catches a design that lets the forced output win or that writes the override into the stored direction bit. It also drives pins whose pad level disagrees with the output latch, so a design that mixes up the data view and the pad view, or that picks the data-view source from the stored direction instead of the effective one, returns the wrong byte. Writes to the pad-view and reserved addresses are followed by reads of all three registers, so any write that leaks into state shows up.

// File: rtl/gpio_ovr_pkg.sv
package gpio_ovr_pkg;
   localparam int unsigned ADDR_W = 2;

   typedef enum logic [ADDR_W-1:0] {
      REG_LATCH = 2'd0,
      REG_PADV  = 2'd1,
      REG_DIR   = 2'd2,
      REG_RSVD  = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/gpio_ovr_sync.sv
module gpio_ovr_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] d_out
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_ovr_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= d_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign d_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_ovr_regs.sv
module gpio_ovr_regs
   import gpio_ovr_pkg::*;
#(
   parameter int unsigned WIDTH = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [WIDTH-1:0]  bus_wdata,
   output logic [WIDTH-1:0]  latch_q,
   output logic [WIDTH-1:0]  dir_q
);
   logic wr_latch;
   logic wr_dir;

   always_comb begin
      wr_latch = 1'b0;
      wr_dir   = 1'b0;
      if (bus_wr) begin
         unique case (reg_sel_e'(bus_addr))
            REG_LATCH: wr_latch = 1'b1;
            REG_DIR:   wr_dir   = 1'b1;
            default:   ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_q <= '0;
         dir_q   <= '0;
      end else begin
         if (wr_latch) latch_q <= bus_wdata;
         if (wr_dir)   dir_q   <= bus_wdata;
      end
   end
endmodule

// File: rtl/gpio_ovr_pinctl.sv
module gpio_ovr_pinctl #(
   parameter int unsigned WIDTH    = 8,
   parameter bit          HAS_SHDN = 1'b1,
   parameter int unsigned SHDN_PIN = WIDTH - 1
) (
   input  logic [WIDTH-1:0] dir_q,
   input  logic [WIDTH-1:0] latch_q,
   input  logic [WIDTH-1:0] pwm_en,
   input  logic [WIDTH-1:0] pwm_val,
   input  logic             shdn_en,
   output logic [WIDTH-1:0] drive,
   output logic [WIDTH-1:0] pad_out
);
   if (HAS_SHDN && SHDN_PIN >= WIDTH) begin : g_bad_pin
      $error("gpio_ovr_pinctl: SHDN_PIN outside the port");
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_pin
      logic wants_out;
      assign wants_out = pwm_en[i] | dir_q[i];
      assign pad_out[i] = pwm_en[i] ? pwm_val[i] : latch_q[i];

      if (HAS_SHDN && i == SHDN_PIN) begin : g_shdn
         assign drive[i] = wants_out & ~shdn_en;
      end else begin : g_plain
         assign drive[i] = wants_out;
      end
   end

   if (!HAS_SHDN) begin : g_no_shdn_use
      logic unused_shdn;
      assign unused_shdn = shdn_en;
   end
endmodule

// File: rtl/gpio_ovr_rdmux.sv
module gpio_ovr_rdmux
   import gpio_ovr_pkg::*;
#(
   parameter int unsigned WIDTH = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [WIDTH-1:0]  latch_q,
   input  logic [WIDTH-1:0]  dir_q,
   input  logic [WIDTH-1:0]  drive,
   input  logic [WIDTH-1:0]  pad_sync,
   output logic [WIDTH-1:0]  bus_rdata
);
   logic [WIDTH-1:0] data_view;
   logic [WIDTH-1:0] sel_val;

   assign data_view = (latch_q & drive) | (pad_sync & ~drive);

   always_comb begin
      unique case (reg_sel_e'(bus_addr))
         REG_LATCH: sel_val = data_view;
         REG_PADV:  sel_val = pad_sync;
         REG_DIR:   sel_val = dir_q;
         default:   sel_val = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= sel_val;
      else             bus_rdata <= '0;
   end
endmodule

// File: rtl/gpio_ovr_port.sv
module gpio_ovr_port
   import gpio_ovr_pkg::*;
#(
   parameter int unsigned WIDTH       = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          HAS_SHDN    = 1'b1,
   parameter int unsigned SHDN_PIN    = WIDTH - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [WIDTH-1:0]  bus_wdata,
   output logic [WIDTH-1:0]  bus_rdata,
   input  logic [WIDTH-1:0]  pwm_en,
   input  logic [WIDTH-1:0]  pwm_val,
   input  logic              shdn_en,
   output logic [WIDTH-1:0]  pad_oe,
   output logic [WIDTH-1:0]  pad_out,
   input  logic [WIDTH-1:0]  pad_in
);
   if (WIDTH < 1 || WIDTH > 32) begin : g_bad_width
      $error("gpio_ovr_port: WIDTH must be 1..32");
   end

   logic [WIDTH-1:0] latch_q;
   logic [WIDTH-1:0] dir_q;
   logic [WIDTH-1:0] drive;
   logic [WIDTH-1:0] pad_sync;

   gpio_ovr_regs #(.WIDTH(WIDTH)) regs_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .latch_q   (latch_q),
      .dir_q     (dir_q)
   );

   gpio_ovr_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (pad_in),
      .d_out (pad_sync)
   );

   gpio_ovr_pinctl #(.WIDTH(WIDTH), .HAS_SHDN(HAS_SHDN), .SHDN_PIN(SHDN_PIN)) pin_i (
      .dir_q   (dir_q),
      .latch_q (latch_q),
      .pwm_en  (pwm_en),
      .pwm_val (pwm_val),
      .shdn_en (shdn_en),
      .drive   (drive),
      .pad_out (pad_out)
   );

   gpio_ovr_rdmux #(.WIDTH(WIDTH)) rd_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_rd    (bus_rd),
      .bus_addr  (bus_addr),
      .latch_q   (latch_q),
      .dir_q     (dir_q),
      .drive     (drive),
      .pad_sync  (pad_sync),
      .bus_rdata (bus_rdata)
   );

   assign pad_oe = drive;
endmodule

// File: rtl/gpio_ovr_port_chk.sv
module gpio_ovr_port_chk #(
   parameter int unsigned WIDTH    = 8,
   parameter int unsigned SHDN_PIN = WIDTH - 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_wr,
   input logic             bus_rd,
   input logic [1:0]       bus_addr,
   input logic [WIDTH-1:0] bus_rdata,
   input logic [WIDTH-1:0] pwm_en,
   input logic [WIDTH-1:0] pwm_val,
   input logic             shdn_en,
   input logic [WIDTH-1:0] pad_oe,
   input logic [WIDTH-1:0] pad_out,
   input logic [WIDTH-1:0] pad_in,
   input logic [WIDTH-1:0] dir_q
);
   localparam logic [WIDTH-1:0] SD_BIT = WIDTH'(1) << SHDN_PIN;

   logic [WIDTH-1:0] sd_mask;
   logic [1:0]       warm_cnt;

   assign sd_mask = shdn_en ? SD_BIT : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                warm_cnt <= '0;
      else if (warm_cnt != 2'd3) warm_cnt <= warm_cnt + 2'd1;
   end

   AST_SHDN_FORCES_IN: assert property (@(posedge clk) disable iff (!rst_n)
      shdn_en |-> !pad_oe[SHDN_PIN]); // R4

   AST_PWM_TAKES_PIN: assert property (@(posedge clk) disable iff (!rst_n)
      (((pwm_en & ~sd_mask & ~pad_oe) == '0) && ((pwm_en & (pad_out ^ pwm_val)) == '0))); // R3

   AST_DIR_HELD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && bus_addr == 2'd2) |=> $stable(dir_q)); // R3

   AST_OE_FROM_DIR: assert property (@(posedge clk) disable iff (!rst_n)
      ((~pwm_en & ~sd_mask & (dir_q ^ pad_oe)) == '0)); // R2

   AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> (bus_rdata == '0)); // R10

   AST_PADVIEW_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == 2'd1 && warm_cnt == 2'd3) |=> (bus_rdata == $past(pad_in, 3))); // R6
endmodule

bind gpio_ovr_port gpio_ovr_port_chk #(.WIDTH(WIDTH), .SHDN_PIN(SHDN_PIN)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_rd    (bus_rd),
   .bus_addr  (bus_addr),
   .bus_rdata (bus_rdata),
   .pwm_en    (pwm_en),
   .pwm_val   (pwm_val),
   .shdn_en   (shdn_en),
   .pad_oe    (pad_oe),
   .pad_out   (pad_out),
   .pad_in    (pad_in),
   .dir_q     (dir_q)
);

// File: tb/gpio_ovr_port_tb.sv
`timescale 1ns/1ps
module gpio_ovr_port_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr = 1'b0;
   logic       bus_rd = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic [7:0] pwm_en = 8'h00;
   logic [7:0] pwm_val = 8'h00;
   logic       shdn_en = 1'b0;
   logic [7:0] pad_oe;
   logic [7:0] pad_out;
   logic [7:0] pad_in = 8'h00;

   int n_chk = 0;
   int n_bad = 0;

   logic [7:0] exp_q [$];
   string      tag_q [$];

   always #5 clk = ~clk;

   gpio_ovr_port dut_i (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pwm_en(pwm_en), .pwm_val(pwm_val), .shdn_en(shdn_en),
      .pad_oe(pad_oe), .pad_out(pad_out), .pad_in(pad_in)
   );

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%02h exp=%02h", tag, act, exp);
      end
   endtask

   // driver: every call starts and ends on a falling edge
   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
      bus_rd = 1'b1; bus_addr = a;
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   // monitor: a read sampled at an edge is compared at the next falling edge
   initial begin
      logic was_rd;
      forever begin
         @(posedge clk);
         was_rd = bus_rd;
         @(negedge clk);
         if (was_rd) begin
            if (exp_q.size() == 0) begin
               check("R10 unexpected response", bus_rdata, 8'hxx);
            end else begin
               logic [7:0] e;
               string      t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               check(t, bus_rdata, e);
            end
         end
      end
   end

   initial begin
      #(200000 * 10);
      n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      check("R1 pad_oe after reset", pad_oe, 8'h00);
      check("R1 rdata after reset", bus_rdata, 8'h00);
      check("R1 pad_out latch after reset", pad_out, 8'h00);
      rd(2'd2, 8'h00, "R1 dir after reset");
      rd(2'd0, 8'h00, "R1 data view after reset");

      wr(2'd2, 8'h0F);
      check("R2 pad_oe follows dir", pad_oe, 8'h0F);
      rd(2'd2, 8'h0F, "R2 dir readback");

      wr(2'd0, 8'hA5);
      check("R8 pad_out from latch", pad_out, 8'hA5);

      pad_in = 8'h3C;
      idle(3);
      rd(2'd0, 8'h35, "R7 data view mix");
      rd(2'd1, 8'h3C, "R5 pad view shows conflict");

      // R6: three back-to-back reads around a pad change
      pad_in = 8'hC3;
      rd(2'd1, 8'h3C, "R6 read at edge E");
      rd(2'd1, 8'h3C, "R6 read at edge E+1");
      rd(2'd1, 8'hC3, "R6 read at edge E+2");
      idle(1);
      check("R10 rdata zero when idle", bus_rdata, 8'h00);

      pwm_en = 8'h30; pwm_val = 8'h10;
      idle(1);
      check("R3 pad_oe with takeover", pad_oe, 8'h3F);
      check("R3 pad_out with takeover", pad_out, 8'h95);
      rd(2'd2, 8'h0F, "R3 dir unchanged by takeover");

      wr(2'd2, 8'hFF);
      pwm_en = 8'hB0; pwm_val = 8'h80; shdn_en = 1'b1;
      idle(1);
      check("R4 shutdown beats takeover", pad_oe, 8'h7F);
      wr(2'd0, 8'h25);
      rd(2'd0, 8'hA5, "R7 shut pin reads pad");
      rd(2'd2, 8'hFF, "R4 dir unchanged by shutdown");
      shdn_en = 1'b0;
      idle(1);
      check("R4 release restores drive", pad_oe, 8'hFF);

      wr(2'd1, 8'h00);
      wr(2'd3, 8'h5A);
      rd(2'd1, 8'hC3, "R9 pad view after ignored write");
      rd(2'd3, 8'h00, "R9 reserved reads zero");
      rd(2'd2, 8'hFF, "R9 dir untouched");
      pwm_en = 8'h00;
      rd(2'd0, 8'h25, "R9 latch untouched");

      wr(2'd2, 8'h00);
      pwm_en = 8'h01;
      pad_in = 8'h00;
      idle(3);
      rd(2'd0, 8'h01, "R7 takeover pin reads latch");
      check("R2 dir write at any time", pad_oe, 8'h01);

      idle(3);
      check("R10 all responses seen", 8'(exp_q.size()), 8'h00);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule